// File: doc/BRIEF.md
# Magic packet wake detector

The block examines received Ethernet frames, delivered one byte per valid cycle, for a wake-up frame. Such a frame carries sixteen back-to-back copies of the station's 48-bit address inside its data field. The destination address is screened in one of two ways. In strict mode it must equal the station address. In relaxed mode any destination passes. The required sequence is the same in both modes.

Bytes 0 to 5 of a frame are the destination, bytes 6 to 11 are the source, and bytes 12 and 13 are the length/type. The search covers frame bytes 14 onward. The block cannot know the frame length ahead of time, so it decides only at end-of-frame. At that point it confirms that the last byte of the sequence came at least four bytes before the final byte, which keeps the FCS out of the match. A positive result sets a sticky flag. The flag is cleared by `clr_i` or by dropping `en_i`.

Top module: `mpkt_wake_det`

## Requirements
- R1: After reset is asserted, `det_o` is 0.
- R2: A frame is detected when its data field holds 96 consecutive bytes forming 16 copies of the station address. Byte k of each copy is `sta_addr_i[47-8k -: 8]`, so bits 47:40 are sent first. `det_o` rises on the clock edge that takes the end-of-frame byte.
- R3: Frame bytes 0 to 13 are never part of the sequence. A sequence whose first byte lies at index 12 or 13 is not detected.
- R4: The sequence may begin at any data offset. A failed partial attempt just before it does not hide it, because the byte that breaks an attempt is re-examined as a possible first byte.
- R5: A single flipped bit in any of the 96 sequence bytes prevents detection of that occurrence.
- R6: Detection requires at least 4 bytes after the last sequence byte, counting up to and including the end-of-frame byte. With 4 such bytes the frame is detected. With 3 or fewer it is not.
- R7: With `relax_i`=0, the destination bytes 0 to 5 must equal the station address in the same byte order as R2. Broadcast and other destinations are rejected.
- R8: With `relax_i`=1, unicast, multicast and broadcast destinations are all accepted.
- R9: `det_o` stays 1 until `clr_i` is asserted. If `clr_i` and a new detection fall in the same cycle, `det_o` remains 1.
- R10: While `en_i`=0, `det_o` is 0 and input bytes are ignored. A frame already in progress when `en_i` rises is ignored until the next start-of-frame.
- R11: Cycles with `vld_i`=0 carry no byte. Idle gaps between bytes do not affect detection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Detection enable |
| relax_i | input | 1 | 1: accept any destination address |
| sta_addr_i | input | 48 | Station address, bits 47:40 are wire byte 0 |
| vld_i | input | 1 | Byte valid |
| sof_i | input | 1 | Marks the first byte of a frame |
| eof_i | input | 1 | Marks the last byte of a frame (last FCS byte) |
| data_i | input | 8 | Received byte |
| clr_i | input | 1 | Clears the detected flag |
| det_o | output | 1 | Sticky detected flag |

## Verification
The assertions take the framing on `vld_i`, `sof_i` and `eof_i` to be well formed: every frame is longer than its 14-byte header, and end-of-frame appears only after a start-of-frame. They also take `relax_i` and `sta_addr_i` to be steady while a frame is in flight. The position tracker falls back only to the first address byte, so exact restarts also assume the six address bytes are distinct. The stimulus keeps within these limits. It uses one address with six different bytes and filler bytes that never equal an address byte. It changes the mode only between frames and always sends complete frames, inserting idle gaps only between bytes.

// File: rtl/mpkt_pkg.sv
package mpkt_pkg;
  typedef logic [7:0] byte_t;
  localparam int unsigned DEF_ADDR_BYTES = 6;
  localparam int unsigned DEF_REPS       = 16;
  localparam int unsigned DEF_HDR_BYTES  = 14;
  localparam int unsigned DEF_FCS_BYTES  = 4;
endpackage

// File: rtl/mpkt_hdr_filter.sv
module mpkt_hdr_filter
  import mpkt_pkg::*;
#(
  parameter int unsigned ADDR_BYTES = DEF_ADDR_BYTES,
  parameter int unsigned HDR_BYTES  = DEF_HDR_BYTES
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic                    vld_i,
  input  logic                    sof_i,
  input  logic                    eof_i,
  input  byte_t                   data_i,
  input  logic [8*ADDR_BYTES-1:0] addr_i,
  output logic                    take_o,
  output logic                    body_o,
  output logic                    da_ok_o
);
  localparam int unsigned IW = $clog2(HDR_BYTES + 1);

  logic          act_q, da_ok_q;
  logic [IW-1:0] idx_q, cur_idx;
  byte_t         exp_b;
  logic          da_hit;

  assign take_o  = en_i & vld_i & (sof_i | act_q);
  assign cur_idx = sof_i ? '0 : idx_q;
  assign body_o  = take_o & (cur_idx == IW'(HDR_BYTES));
  assign da_ok_o = da_ok_q;

  always_comb begin
    exp_b = '0;
    for (int i = 0; i < ADDR_BYTES; i++)
      if (cur_idx == IW'(i)) exp_b = addr_i[8*(ADDR_BYTES-1-i) +: 8];
  end

  assign da_hit = (cur_idx >= IW'(ADDR_BYTES)) | (data_i == exp_b);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q   <= 1'b0;
      idx_q   <= '0;
      da_ok_q <= 1'b0;
    end else if (!en_i) begin
      act_q   <= 1'b0;
      idx_q   <= '0;
      da_ok_q <= 1'b0;
    end else if (take_o) begin
      act_q   <= ~eof_i;
      idx_q   <= (cur_idx == IW'(HDR_BYTES)) ? cur_idx : cur_idx + IW'(1);
      da_ok_q <= (sof_i | da_ok_q) & da_hit;
    end
  end
endmodule

// File: rtl/mpkt_seq_track.sv
module mpkt_seq_track
  import mpkt_pkg::*;
#(
  parameter int unsigned ADDR_BYTES = DEF_ADDR_BYTES,
  parameter int unsigned REPS       = DEF_REPS
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic                    restart_i,
  input  logic                    step_i,
  input  byte_t                   data_i,
  input  logic [8*ADDR_BYTES-1:0] addr_i,
  output logic                    hit_o,
  output logic                    found_o
);
  localparam int unsigned KW = $clog2(ADDR_BYTES);
  localparam int unsigned RW = $clog2(REPS);

  logic [KW-1:0] k_q;
  logic [RW-1:0] r_q;
  logic          found_q;
  byte_t         exp_b, first_b;
  logic          match, last_k, last_r, live;

  always_comb begin
    exp_b = '0;
    for (int i = 0; i < ADDR_BYTES; i++)
      if (k_q == KW'(i)) exp_b = addr_i[8*(ADDR_BYTES-1-i) +: 8];
  end

  assign first_b = addr_i[8*ADDR_BYTES-1 -: 8];
  assign match   = data_i == exp_b;
  assign last_k  = k_q == KW'(ADDR_BYTES - 1);
  assign last_r  = r_q == RW'(REPS - 1);
  assign live    = step_i & ~found_q;
  assign hit_o   = live & match & last_k & last_r;
  assign found_o = found_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      k_q <= '0; r_q <= '0; found_q <= 1'b0;
    end else if (!en_i || restart_i) begin
      k_q <= '0; r_q <= '0; found_q <= 1'b0;
    end else if (live) begin
      if (hit_o) begin
        found_q <= 1'b1;
      end else if (match) begin
        if (last_k) begin
          k_q <= '0;
          r_q <= r_q + RW'(1);
        end else begin
          k_q <= k_q + KW'(1);
        end
      end else begin
        // breaking byte may open a new attempt
        k_q <= (data_i == first_b) ? KW'(1) : '0;
        r_q <= '0;
      end
    end
  end
endmodule

// File: rtl/mpkt_tail_guard.sv
module mpkt_tail_guard
  import mpkt_pkg::*;
#(
  parameter int unsigned FCS_BYTES = DEF_FCS_BYTES
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic restart_i,
  input  logic take_i,
  input  logic hit_i,
  output logic clear_o
);
  localparam int unsigned TW  = $clog2(FCS_BYTES + 1);
  localparam int unsigned LIM = FCS_BYTES - 1;

  logic [TW-1:0] tail_q;

  // bytes seen after the completing byte, excluding the current one
  assign clear_o = tail_q >= TW'(LIM);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          tail_q <= '0;
    else if (!en_i || restart_i || hit_i) tail_q <= '0;
    else if (take_i && !clear_o)          tail_q <= tail_q + TW'(1);
  end
endmodule

// File: rtl/mpkt_wake_det.sv
module mpkt_wake_det
  import mpkt_pkg::*;
#(
  parameter int unsigned ADDR_BYTES = DEF_ADDR_BYTES,
  parameter int unsigned REPS       = DEF_REPS,
  parameter int unsigned HDR_BYTES  = DEF_HDR_BYTES,
  parameter int unsigned FCS_BYTES  = DEF_FCS_BYTES
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic                    relax_i,
  input  logic [8*ADDR_BYTES-1:0] sta_addr_i,
  input  logic                    vld_i,
  input  logic                    sof_i,
  input  logic                    eof_i,
  input  logic [7:0]              data_i,
  input  logic                    clr_i,
  output logic                    det_o
);
  logic take, body, da_ok, seq_hit, seq_found, tail_clear, restart, det_set, det_q;

  assign restart = take & sof_i;

  mpkt_hdr_filter #(.ADDR_BYTES(ADDR_BYTES), .HDR_BYTES(HDR_BYTES)) u_hdr (
    .clk_i, .rst_ni, .en_i, .vld_i, .sof_i, .eof_i,
    .data_i  (byte_t'(data_i)),
    .addr_i  (sta_addr_i),
    .take_o  (take),
    .body_o  (body),
    .da_ok_o (da_ok)
  );

  mpkt_seq_track #(.ADDR_BYTES(ADDR_BYTES), .REPS(REPS)) u_seq (
    .clk_i, .rst_ni, .en_i,
    .restart_i (restart),
    .step_i    (body),
    .data_i    (byte_t'(data_i)),
    .addr_i    (sta_addr_i),
    .hit_o     (seq_hit),
    .found_o   (seq_found)
  );

  mpkt_tail_guard #(.FCS_BYTES(FCS_BYTES)) u_tail (
    .clk_i, .rst_ni, .en_i,
    .restart_i (restart),
    .take_i    (take),
    .hit_i     (seq_hit),
    .clear_o   (tail_clear)
  );

  assign det_set = take & eof_i & seq_found & tail_clear & (relax_i | da_ok);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      det_q <= 1'b0;
    else if (!en_i)   det_q <= 1'b0;
    else if (det_set) det_q <= 1'b1;
    else if (clr_i)   det_q <= 1'b0;
  end

  assign det_o = det_q;
endmodule

// File: rtl/mpkt_wake_det_chk.sv
module mpkt_wake_det_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic relax_i,
  input logic vld_i,
  input logic eof_i,
  input logic clr_i,
  input logic da_ok,
  input logic seq_found,
  input logic det_o
);
  AST_OFF_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !det_o); // R10
  AST_SET_AT_EOF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(det_o) |-> $past(vld_i && eof_i && en_i)); // R2
  AST_SET_NEEDS_SEQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(det_o) |-> $past(seq_found)); // R2
  AST_STRICT_DA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(det_o) && !$past(relax_i) |-> $past(da_ok)); // R7
  AST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    det_o && en_i && !clr_i |=> det_o); // R9
  AST_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && clr_i && !(vld_i && eof_i) |=> !det_o); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_i && !clr_i && en_i |=> $stable(det_o)); // R11
endmodule

bind mpkt_wake_det mpkt_wake_det_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .en_i      (en_i),
  .relax_i   (relax_i),
  .vld_i     (vld_i),
  .eof_i     (eof_i),
  .clr_i     (clr_i),
  .da_ok     (da_ok),
  .seq_found (seq_found),
  .det_o     (det_o)
);

// File: tb/mpkt_wake_det_test.sv
`timescale 1ns/1ps
module mpkt_wake_det_test;
  localparam logic [47:0] STA = 48'h123456789ABC;
  localparam int NONE = 255;

  typedef struct packed {
    logic [7:0] start;
    logic [7:0] part;
    logic [7:0] flip;
    logic [7:0] trail;
    logic [1:0] da;
    logic       relax;
    logic       gap;
    logic       expd;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{8'd14, 8'd0,  8'd255, 8'd4,  2'd0, 1'b0, 1'b0, 1'b1}, // R2 at data start
    '{8'd37, 8'd0,  8'd255, 8'd10, 2'd0, 1'b0, 1'b0, 1'b1}, // R4 odd offset
    '{8'd20, 8'd3,  8'd255, 8'd6,  2'd0, 1'b0, 1'b0, 1'b1}, // R4 partial copy first
    '{8'd14, 8'd33, 8'd255, 8'd4,  2'd0, 1'b0, 1'b0, 1'b1}, // R4 long failed attempt
    '{8'd14, 8'd0,  8'd0,   8'd8,  2'd0, 1'b0, 1'b0, 1'b0}, // R5 first byte bad
    '{8'd14, 8'd0,  8'd95,  8'd8,  2'd0, 1'b0, 1'b0, 1'b0}, // R5 last byte bad
    '{8'd20, 8'd0,  8'd50,  8'd8,  2'd0, 1'b0, 1'b0, 1'b0}, // R5 middle byte bad
    '{8'd40, 8'd0,  8'd255, 8'd4,  2'd0, 1'b0, 1'b0, 1'b1}, // R6 exactly four after
    '{8'd40, 8'd0,  8'd255, 8'd3,  2'd0, 1'b0, 1'b0, 1'b0}, // R6 ends in FCS
    '{8'd40, 8'd0,  8'd255, 8'd1,  2'd0, 1'b0, 1'b0, 1'b0}, // R6 one byte after
    '{8'd12, 8'd0,  8'd255, 8'd8,  2'd0, 1'b0, 1'b0, 1'b0}, // R3 starts in type
    '{8'd13, 8'd0,  8'd255, 8'd8,  2'd0, 1'b0, 1'b0, 1'b0}, // R3 starts at 13
    '{8'd14, 8'd0,  8'd255, 8'd4,  2'd3, 1'b0, 1'b0, 1'b0}, // R7 foreign unicast
    '{8'd14, 8'd0,  8'd255, 8'd4,  2'd1, 1'b0, 1'b0, 1'b0}, // R7 broadcast rejected
    '{8'd14, 8'd0,  8'd255, 8'd4,  2'd1, 1'b1, 1'b0, 1'b1}, // R8 broadcast
    '{8'd22, 8'd0,  8'd255, 8'd5,  2'd2, 1'b1, 1'b0, 1'b1}, // R8 multicast
    '{8'd14, 8'd0,  8'd255, 8'd4,  2'd0, 1'b0, 1'b1, 1'b1}  // R11 gapped bytes
  };

  logic clk = 1'b0, rst_ni = 1'b0, en_i = 1'b1, relax_i = 1'b0;
  logic vld_i = 1'b0, sof_i = 1'b0, eof_i = 1'b0, clr_i = 1'b0;
  logic [7:0] data_i = '0;
  logic det_o;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  mpkt_wake_det uut (
    .clk_i(clk), .rst_ni, .en_i, .relax_i, .sta_addr_i(STA),
    .vld_i, .sof_i, .eof_i, .data_i, .clr_i, .det_o
  );

  function automatic logic [7:0] ab(int k);
    return STA[8*(5-(k%6)) +: 8];
  endfunction

  function automatic logic [7:0] dab(int kind, int k);
    case (kind)
      0: return ab(k);
      1: return 8'hFF;
      2: return (k == 0) ? 8'h01 : (k == 2) ? 8'h5E : 8'h00;
      default: return 8'h10 + 8'(k);
    endcase
  endfunction

  task automatic check(logic got, logic exp, string what);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: det_o=%0b expected %0b", what, got, exp);
    end
  endtask

  task automatic send_frame(int start, int part, int flip, int trail, int da,
                            bit gap, bit clr_eof, int en_at);
    logic [7:0] fb [0:255];
    int len, s0;
    for (int i = 0; i < 6; i++) fb[i] = dab(da, i);
    for (int i = 6; i < 12; i++) fb[i] = (i == 6) ? 8'h02 : (i == 11) ? 8'h01 : 8'h00;
    fb[12] = 8'h08; fb[13] = 8'h00;
    for (int i = 14; i < start; i++) fb[i] = 8'h55;
    for (int p = 0; p < part; p++) fb[start+p] = ab(p);
    s0 = start + part;
    for (int q = 0; q < 96; q++) fb[s0+q] = ab(q) ^ ((q == flip) ? 8'h01 : 8'h00);
    for (int t = 0; t < trail; t++) fb[s0+96+t] = (t < trail - 4) ? 8'h33 : 8'hAA;
    len = s0 + 96 + trail;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (i == en_at) en_i = 1'b1;
      vld_i = 1'b1; sof_i = (i == 0); eof_i = (i == len - 1);
      data_i = fb[i]; clr_i = clr_eof && (i == len - 1);
      if (gap && i < len - 1) begin
        @(negedge clk);
        vld_i = 1'b0; sof_i = 1'b0; eof_i = 1'b0; clr_i = 1'b0;
      end
    end
    @(negedge clk);
    vld_i = 1'b0; sof_i = 1'b0; eof_i = 1'b0; clr_i = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse_clr();
    @(negedge clk); clr_i = 1'b1;
    @(negedge clk); clr_i = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: det_o=%0b expected run end", det_o);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(det_o, 1'b0, "R1 in reset");
    rst_ni = 1'b1;
    @(negedge clk);
    check(det_o, 1'b0, "R1 after reset");

    for (int v = 0; v < NV; v++) begin
      relax_i = VECS[v].relax;
      pulse_clr();
      send_frame(int'(VECS[v].start), int'(VECS[v].part), int'(VECS[v].flip),
                 int'(VECS[v].trail), int'(VECS[v].da), VECS[v].gap, 1'b0, -1);
      check(det_o, VECS[v].expd, $sformatf("vector %0d", v));
    end
    relax_i = 1'b0;

    // R9 sticky across a non-matching frame, then clear
    pulse_clr();
    send_frame(14, 0, NONE, 4, 0, 1'b0, 1'b0, -1);
    check(det_o, 1'b1, "R2 detect before sticky test");
    send_frame(14, 0, 30, 4, 0, 1'b0, 1'b0, -1);
    check(det_o, 1'b1, "R9 held over bad frame");
    pulse_clr();
    check(det_o, 1'b0, "R9 cleared");
    // R9 set wins over same-cycle clear
    send_frame(14, 0, NONE, 4, 0, 1'b0, 1'b1, -1);
    check(det_o, 1'b1, "R9 set beats clear");

    // R10 disable drops flag, ignores frames
    @(negedge clk); en_i = 1'b0;
    @(negedge clk);
    check(det_o, 1'b0, "R10 low when disabled");
    send_frame(14, 0, NONE, 4, 0, 1'b0, 1'b0, -1);
    check(det_o, 1'b0, "R10 frame ignored while disabled");
    @(negedge clk); en_i = 1'b1;
    repeat (2) @(negedge clk);
    check(det_o, 1'b0, "R10 nothing latched while disabled");
    // R10 enable mid-frame
    en_i = 1'b0;
    send_frame(14, 0, NONE, 4, 0, 1'b0, 1'b0, 3);
    check(det_o, 1'b0, "R10 mid-frame enable ignored");
    send_frame(14, 0, NONE, 4, 0, 1'b0, 1'b0, -1);
    check(det_o, 1'b1, "R10 next frame seen");

    // R1 reset clears a set flag
    @(negedge clk); rst_ni = 1'b0;
    @(negedge clk);
    check(det_o, 1'b0, "R1 reset clears flag");
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule